// File: doc/BRIEF.md
# Broadcast-Input Systolic Convolution Array

This block computes a one-dimensional convolution over a stream of signed samples with a fixed set of `TAPS` signed weights. It produces y_i = w1·x_i + w2·x_(i+1) + … + wTAPS·x_(i+TAPS−1). The block is a row of multiply-accumulate cells, and each cell holds one weight. Every accepted sample goes to all cells in the same cycle. A chain of partial sums moves one cell to the right per accepted sample. A fresh zero sum enters at the left end, and a finished sum leaves at the right end.

The weights are preloaded one per cycle through a small write port that is addressed by cell index. After that, samples are streamed in with a valid flag. When the valid flag is low, the array stalls and every partial sum stays in place. Once the array has accepted `TAPS` samples, each further accepted sample produces one complete result, flagged valid in the cycle that follows. Results leave in order y1, y2, and so on, so n samples yield n+1−TAPS results.

Top module: `bcast_conv_array`

## Requirements
- R1: A synchronous reset clears every partial sum, so `res_data` reads 0 and `res_valid` is low after reset. The fill count also restarts: the first TAPS−1 samples accepted after reset produce no valid result.
- R2: A write with `wt_we` high stores `wt_data` into the cell selected by `wt_idx`. Index 0 holds w1, the weight applied to the oldest sample of each window, and index TAPS−1 holds wTAPS, the weight applied to the newest.
- R3: A weight write with `wt_idx` of TAPS or more changes no stored weight.
- R4: Each valid `res_data` equals the exact signed two's-complement sum w1·x_i + … + wTAPS·x_(i+TAPS−1), carried at ACC_W = 2·DATA_W + ceil(log2 TAPS) bits, so even the extreme input values give the exact result with no saturation.
- R5: `res_valid` is high in the cycle after the clock edge that accepts the TAPS-th and each later sample since reset, and it is low in every other cycle. Results come out in order y1, y2, …, and n accepted samples give n+1−TAPS valid results.
- R6: A cycle with `smp_valid` low accepts no sample. In the following cycle `res_valid` is low and `res_data` is unchanged.
- R7: Reset leaves the stored weights unchanged, so a new run after reset needs no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the partial sums and the fill count |
| wt_we | input | 1 | Weight write strobe |
| wt_idx | input | IDX_W | Cell index of the weight write (0 = w1) |
| wt_data | input | DATA_W | Signed weight value |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | DATA_W | Signed sample, sent to all cells |
| res_valid | output | 1 | res_data holds a complete result |
| res_data | output | ACC_W | Signed result from the right-most cell |

## Verification
A table-driven run with mixed-sign weights and samples, fed back to back, confirms the window arithmetic and the start of the valid flag. The same data is then fed with idle gaps between samples, which shows apart a design that stalls properly from one that shifts or flags results on idle cycles. An impulse placed in the middle of an otherwise zero stream makes the results read back the weights in reverse. This shows whether the index-to-weight mapping and the direction of the shift are correct. Runs with all weights and samples at the most negative value, a rerun after an out-of-range write, and a rerun after a reset without reload show apart overflow, a stray write and weights lost on reset.

// File: rtl/bconv_pkg.sv
package bconv_pkg;

    // Full-precision accumulator width for TAPS products of two dw-bit values.
    function automatic int acc_width(input int dw, input int taps);
        return 2 * dw + $clog2(taps);
    endfunction

    // Width of a cell index; never below one bit.
    function automatic int idx_width(input int taps);
        return (taps > 1) ? $clog2(taps) : 1;
    endfunction

endpackage

// File: rtl/bconv_weight_bank.sv
module bconv_weight_bank #(
    parameter int DATA_W = 8,
    parameter int TAPS   = 3,
    parameter int IDX_W  = 2
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [TAPS*DATA_W-1:0]   w_flat
);

    // One weight register per cell; indices at or beyond TAPS match nothing.
    // Weights are deliberately outside the reset domain.
    for (genvar j = 0; j < TAPS; j++) begin : g_slot
        logic [DATA_W-1:0] w_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(j))) begin
                w_q <= wr_data;
            end
        end
        assign w_flat[j*DATA_W +: DATA_W] = w_q;
    end

endmodule

// File: rtl/bconv_cell.sv
module bconv_cell #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step,
    input  logic signed [DATA_W-1:0] x_bcast,
    input  logic signed [DATA_W-1:0] w_local,
    input  logic signed [ACC_W-1:0]  sum_in,
    output logic signed [ACC_W-1:0]  sum_out
);

    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;

    assign prod     = PROD_W'(x_bcast) * PROD_W'(w_local);
    assign prod_ext = ACC_W'(prod);

    // The partial sum from the left neighbour picks up this cell's term and moves right.
    always_ff @(posedge clk) begin
        if (rst) begin
            sum_out <= '0;
        end else if (step) begin
            sum_out <= sum_in + prod_ext;
        end
    end

endmodule

// File: rtl/bconv_fill_tracker.sv
module bconv_fill_tracker #(
    parameter int TAPS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic full_valid
);

    localparam int CNT_W = (TAPS > 1) ? $clog2(TAPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TAPS - 1);

    // Counts accepted samples up to TAPS-1, then saturates.
    logic [CNT_W-1:0] seen_q;
    logic             primed;

    assign primed = (seen_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q     <= '0;
            full_valid <= 1'b0;
        end else begin
            full_valid <= step && primed;
            if (step && !primed) begin
                seen_q <= seen_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcast_conv_array.sv
module bcast_conv_array
    import bconv_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TAPS   = 3,
    parameter int IDX_W  = idx_width(TAPS),
    parameter int ACC_W  = acc_width(DATA_W, TAPS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wt_we,
    input  logic [IDX_W-1:0]         wt_idx,
    input  logic [DATA_W-1:0]        wt_data,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] smp_data,
    output logic                     res_valid,
    output logic signed [ACC_W-1:0]  res_data
);

    logic [TAPS*DATA_W-1:0] w_flat;
    logic signed [ACC_W-1:0] chain [TAPS+1];

    bconv_weight_bank #(
        .DATA_W (DATA_W),
        .TAPS   (TAPS),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk     (clk),
        .wr_en   (wt_we),
        .wr_idx  (wt_idx),
        .wr_data (wt_data),
        .w_flat  (w_flat)
    );

    // A zero partial sum enters the left-most cell with every accepted sample.
    assign chain[0] = '0;

    for (genvar j = 0; j < TAPS; j++) begin : g_cell
        bconv_cell #(
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W)
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .step    (smp_valid),
            .x_bcast (smp_data),
            .w_local (w_flat[j*DATA_W +: DATA_W]),
            .sum_in  (chain[j]),
            .sum_out (chain[j+1])
        );
    end

    bconv_fill_tracker #(
        .TAPS (TAPS)
    ) u_fill (
        .clk        (clk),
        .rst        (rst),
        .step       (smp_valid),
        .full_valid (res_valid)
    );

    assign res_data = chain[TAPS];

endmodule

// File: rtl/bcast_conv_array_chk.sv
module bcast_conv_array_chk #(
    parameter int TAPS  = 3,
    parameter int ACC_W = 18
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    smp_valid,
    input logic                    res_valid,
    input logic signed [ACC_W-1:0] res_data
);

    localparam int CW = $clog2(TAPS + 1);

    logic [CW-1:0] taken_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= '0;
        end else if (smp_valid && (taken_q != CW'(TAPS))) begin
            taken_q <= taken_q + 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && res_data == '0));

    // R5
    valid_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(smp_valid));

    // R5
    valid_needs_fill_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (taken_q == CW'(TAPS)));

    // R6
    stall_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !res_valid);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(res_data));

endmodule

bind bcast_conv_array bcast_conv_array_chk #(
    .TAPS  (TAPS),
    .ACC_W (ACC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/bcast_conv_array_bench.sv
module bcast_conv_array_bench;

    localparam int DW = 8;
    localparam int K  = 3;
    localparam int IW = 2;
    localparam int AW = 2 * DW + 2;
    localparam int NT = 10;

    localparam logic signed [DW-1:0] TBL_W [0:K-1]  = '{8'sd2, -8'sd3, 8'sd5};
    localparam logic signed [DW-1:0] TBL_X [0:NT-1] = '{8'sd1, 8'sd4, -8'sd2, 8'sd7, 8'sd0,
                                                        -8'sd9, 8'sd3, 8'sd12, -8'sd5, 8'sd6};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wt_we = 1'b0;
    logic [IW-1:0] wt_idx = '0;
    logic [DW-1:0] wt_data = '0;
    logic smp_valid = 1'b0;
    logic signed [DW-1:0] smp_data = '0;
    logic res_valid;
    logic signed [AW-1:0] res_data;

    always #2 clk = ~clk;

    bcast_conv_array u_bcast_conv_array (
        .clk       (clk),
        .rst       (rst),
        .wt_we     (wt_we),
        .wt_idx    (wt_idx),
        .wt_data   (wt_data),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    int checks = 0;
    int errors = 0;
    logic signed [DW-1:0] ws [0:K-1];
    logic signed [DW-1:0] xs [0:15];
    int nx;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Convolution window ending at sample index last.
    function automatic longint ref_y(input int last);
        longint s = 0;
        for (int m = 0; m < K; m++) begin
            s += longint'(ws[m]) * longint'(xs[last - K + 1 + m]);
        end
        return s;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load_weights();
        for (int m = 0; m < K; m++) begin
            @(negedge clk);
            wt_we = 1'b1;
            wt_idx = IW'(m);
            wt_data = ws[m];
        end
        @(negedge clk);
        wt_we = 1'b0;
    endtask

    // Streams xs[0..nx-1]; gap idle cycles follow each sample.
    task automatic run(input string req, input int gap);
        int got = 0;
        longint held;
        @(negedge clk);
        for (int t = 0; t < nx; t++) begin
            smp_valid = 1'b1;
            smp_data = xs[t];
            @(negedge clk);
            chk("R5", longint'(res_valid), longint'(t + 1 >= K));
            if (res_valid) begin
                got++;
                chk(req, longint'(res_data), ref_y(t));
            end
            held = longint'(res_data);
            for (int g = 0; g < gap; g++) begin
                smp_valid = 1'b0;
                smp_data = xs[t] ^ 8'h5a;
                @(negedge clk);
                chk("R6", longint'(res_valid), 0);
                chk("R6", longint'(res_data), held);
            end
        end
        smp_valid = 1'b0;
        chk("R5", longint'(got), longint'(nx + 1 - K));
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R1", longint'(res_valid), 0);
        chk("R1", longint'(res_data), 0);

        // Table run, back to back
        for (int m = 0; m < K; m++) ws[m] = TBL_W[m];
        for (int t = 0; t < NT; t++) xs[t] = TBL_X[t];
        nx = NT;
        load_weights();
        run("R4", 0);

        // Same data with idle gaps
        do_reset();
        run("R6", 2);

        // Out-of-range write, then reset without reload (R3, R7)
        @(negedge clk);
        wt_we = 1'b1;
        wt_idx = 2'd3;
        wt_data = 8'h7f;
        @(negedge clk);
        wt_we = 1'b0;
        do_reset();
        run("R3", 0);
        do_reset();
        run("R7", 0);

        // Extremes: exact full-precision sums
        for (int m = 0; m < K; m++) ws[m] = -8'sd128;
        for (int t = 0; t < 6; t++) xs[t] = (t == 3) ? 8'sd127 : -8'sd128;
        nx = 6;
        load_weights();
        do_reset();
        run("R4", 0);
        chk("R4", ref_y(2), 49152);

        // Impulse reveals weight order: y1 = w3, y2 = w2, y3 = w1
        ws[0] = 8'sd3; ws[1] = -8'sd5; ws[2] = 8'sd7;
        xs[0] = 0; xs[1] = 0; xs[2] = 8'sd1; xs[3] = 0; xs[4] = 0;
        nx = 5;
        load_weights();
        do_reset();
        run("R2", 0);
        chk("R2", ref_y(2), 7);

        // Reset mid-run: fill restarts
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data = 8'sd9;
        repeat (4) @(negedge clk);
        smp_valid = 1'b0;
        do_reset();
        @(negedge clk);
        chk("R1", longint'(res_data), 0);
        run("R1", 0);

        finish_run();
    end

endmodule